// File: doc/BRIEF.md
# Two-Phase Transmit Enable Burst Generator

This block produces a transmit-enable waveform built from two kinds of period, called type 0 and type 1. Each type has its own high-time count and low-time count. A period of a type holds the output high for its high count, then low for its low count. Each type also has a 5-bit run length: that many periods of the type play back to back before the generator turns to the other type. A run length of zero removes that type from the rotation.

Software loads the settings through a small write port of eight 16-bit slots. The settings are shadow copies. They are taken into the generator only when an update pulse arrives. That pulse clears every counter and starts the pattern again at the start of type 0, with the output high. After reset the generator stays idle, with its output low, until the first update.

A second output, the frame strobe, normally passes an external strobe through. A 2-bit routing field in the control slot can send the internal update pulse or the transmit-enable waveform to that output instead. An optional registered mode gives a transmit-enable output that cannot glitch.

Top module: `txen_burst_gen`

## Requirements
- R1: After reset `txen` is low and stays low until the first `update` pulse, whatever is written through the configuration port.
- R2: On the clock after an `update` pulse (when either run length is nonzero), `txen` goes high for the type-0 high count in clocks, then low for the type-0 low count in clocks.
- R3: Periods of one type repeat for that type's run length, then the other type runs for its run length, and the two keep alternating.
- R4: A run length of zero removes that type. If only one run length is nonzero, that type repeats for as long as the generator runs. If type 0 is removed, the pattern starts with type 1.
- R5: An `update` taken while both run lengths are zero leaves `txen` low and the generator idle.
- R6: A high or low count of zero acts as a one-clock segment.
- R7: Slots 0..3 hold the type-0 low, type-0 high, type-1 low and type-1 high counts. Slot 7 holds the routing mode in bits [11:10], the type-1 run length in bits [9:5] and the type-0 run length in bits [4:0]. Writes to slots 4..6 have no effect. Writes change the waveform only from the next `update` onward.
- R8: An `update` in the middle of a pattern restarts it at once from the start of type 0.
- R9: The routing mode taken at the last update is used. When `route_en` is low, or the mode is 00 or 01, `fs_out` equals `fs_in`. Mode 10 drives `fs_out` with `update`, and mode 11 drives it with `txen`.
- R10: With `sync_en` high, `txen` comes from a flip-flop and follows the pattern one clock later than with `sync_en` low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration slot index |
| cfg_wdata | input | 16 | Configuration write data |
| update | input | 1 | One-clock update pulse that loads settings and restarts the pattern |
| route_en | input | 1 | Enables frame-strobe routing |
| sync_en | input | 1 | Selects the registered transmit-enable output |
| fs_in | input | 1 | External frame strobe, passed through when not routed |
| txen | output | 1 | Transmit-enable waveform |
| fs_out | output | 1 | Frame-strobe output |

## Verification
A wrong segment counter, a wrong repetition count or a wrong type selection shows up on `txen` as an edge at the wrong clock. This is visible within one period of the faulty type, since each sample is compared with an expected waveform computed clock by clock. A wrong routing choice appears on `fs_out` at the first sample after the update. Because the active settings are copied only at an update, the copy can be checked by writing new values mid-pattern and seeing the old waveform continue without change.

// File: rtl/txen_burst_gen.sv
module txen_burst_gen #(
  parameter int CW = 16,
  parameter int LW = 5,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          update,
  input  logic          route_en,
  input  logic          sync_en,
  input  logic          fs_in,
  output logic          txen,
  output logic          fs_out
);

  localparam int MB = 2 * LW;

  logic [CW-1:0] s_lo [2];
  logic [CW-1:0] s_hi [2];
  logic [LW-1:0] s_len [2];
  logic [1:0]    s_mode;

  logic [CW-1:0] a_lo [2];
  logic [CW-1:0] a_hi [2];
  logic [LW-1:0] a_len [2];
  logic [1:0]    a_mode;

  logic          run, hi, ph, txq;
  logic [CW-1:0] cnt;
  logic [LW-1:0] rep;

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  logic nz0, nz1, seg_end, period_end, rep_done, nph, raw;

  assign nz0        = s_len[0] != '0;
  assign nz1        = s_len[1] != '0;
  assign seg_end    = cnt == '0;
  assign period_end = run && seg_end && !hi;
  assign rep_done   = LW'(rep + 1'b1) == a_len[ph];
  assign nph        = (rep_done && a_len[~ph] != '0) ? ~ph : ph;
  assign raw        = run & hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        s_lo[i] <= '0; s_hi[i] <= '0; s_len[i] <= '0;
        a_lo[i] <= '0; a_hi[i] <= '0; a_len[i] <= '0;
      end
      s_mode <= '0;
      a_mode <= '0;
      run <= 1'b0;
      hi  <= 1'b0;
      ph  <= 1'b0;
      cnt <= '0;
      rep <= '0;
      txq <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          AW'(0): s_lo[0] <= cfg_wdata;
          AW'(1): s_hi[0] <= cfg_wdata;
          AW'(2): s_lo[1] <= cfg_wdata;
          AW'(3): s_hi[1] <= cfg_wdata;
          AW'(7): begin
            s_mode   <= cfg_wdata[MB+1:MB];
            s_len[1] <= cfg_wdata[MB-1:LW];
            s_len[0] <= cfg_wdata[LW-1:0];
          end
          default: ;
        endcase
      end
      if (update) begin
        for (int i = 0; i < 2; i++) begin
          a_lo[i]  <= s_lo[i];
          a_hi[i]  <= s_hi[i];
          a_len[i] <= s_len[i];
        end
        a_mode <= s_mode;
        run <= nz0 | nz1;
        ph  <= ~nz0;
        hi  <= 1'b1;
        cnt <= ld(nz0 ? s_hi[0] : s_hi[1]);
        rep <= '0;
      end else if (run) begin
        if (!seg_end) begin
          cnt <= cnt - 1'b1;
        end else if (hi) begin
          hi  <= 1'b0;
          cnt <= ld(a_lo[ph]);
        end else begin
          hi  <= 1'b1;
          ph  <= nph;
          rep <= rep_done ? '0 : rep + 1'b1;
          cnt <= ld(a_hi[nph]);
        end
      end
      txq <= raw;
    end
  end

  assign txen   = sync_en ? txq : raw;
  assign fs_out = (route_en && a_mode[1]) ? (a_mode[0] ? txen : update) : fs_in;

endmodule

module txen_burst_gen_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          update,
  input logic          sync_en,
  input logic          run,
  input logic          hi,
  input logic          ph,
  input logic          period_end,
  input logic          raw,
  input logic          txen,
  input logic [LW-1:0] sl0,
  input logic [LW-1:0] sl1,
  input logic [LW-1:0] al0,
  input logic [LW-1:0] al1
);

  assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (update && (sl0 != '0 || sl1 != '0)) |=> (run && hi));

  assert_idle_both_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (update && sl0 == '0 && sl1 == '0) |=> !run);

  assert_type_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!update && !period_end) |=> $stable(ph));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable({al0, al1}));

  assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |-> (txen == $past(raw)));

endmodule

bind txen_burst_gen txen_burst_gen_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .update(update), .sync_en(sync_en),
  .run(run), .hi(hi), .ph(ph), .period_end(period_end), .raw(raw),
  .txen(txen), .sl0(s_len[0]), .sl1(s_len[1]), .al0(a_len[0]), .al1(a_len[1])
);

// File: tb/txen_burst_gen_test.sv
module txen_burst_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        update = 1'b0;
  logic        route_en = 1'b0;
  logic        sync_en = 1'b0;
  logic        fs_in = 1'b1;
  logic        txen, fs_out;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  t;
    logic  f;
    string tag;
  } item_t;

  item_t q[$];

  txen_burst_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .update(update), .route_en(route_en),
    .sync_en(sync_en), .fs_in(fs_in), .txen(txen), .fs_out(fs_out)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, "txen", txen, it.t);
      check(it.tag, "fs_out", fs_out, it.f);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic run_pattern(input int h0, input int l0, input int h1, input int l1,
                             input int n0, input int n1, input logic [1:0] mode,
                             input int ncyc, input logic sy, input logic disturb,
                             input string tag);
    logic raw [0:255];
    int hh[2], ll[2], nn[2];
    int k;
    logic ph;
    wr(3'd0, 16'(l0)); wr(3'd1, 16'(h0)); wr(3'd2, 16'(l1)); wr(3'd3, 16'(h1));
    wr(3'd7, {4'h0, mode, 5'(n1), 5'(n0)});
    wr(3'd4, 16'hffff); wr(3'd5, 16'hffff); wr(3'd6, 16'hffff);
    for (int i = 0; i < 256; i++) raw[i] = 1'b0;
    hh[0] = (h0 == 0) ? 1 : h0; hh[1] = (h1 == 0) ? 1 : h1;
    ll[0] = (l0 == 0) ? 1 : l0; ll[1] = (l1 == 0) ? 1 : l1;
    nn[0] = n0; nn[1] = n1;
    k = 0;
    ph = (n0 == 0);
    while (k < ncyc && (n0 != 0 || n1 != 0)) begin
      for (int p = 0; p < nn[ph] && k < ncyc; p++) begin
        for (int i = 0; i < hh[ph] && k < ncyc; i++) begin raw[k] = 1'b1; k++; end
        for (int i = 0; i < ll[ph] && k < ncyc; i++) begin raw[k] = 1'b0; k++; end
      end
      if (nn[~ph] != 0) ph = ~ph;
    end
    @(negedge clk);
    sync_en = sy;
    update = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      item_t it;
      it.t = sy ? ((i == 0) ? 1'b0 : raw[i-1]) : raw[i];
      if (route_en && mode[1]) it.f = mode[0] ? it.t : (i == 0);
      else it.f = fs_in;
      it.tag = tag;
      q.push_back(it);
    end
    @(negedge clk);
    update = 1'b0;
    if (disturb) begin
      wr(3'd0, 16'd9); wr(3'd1, 16'd9); wr(3'd7, 16'h0021);
    end
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset txen", txen, 1'b0);
    check("R1", "reset fs_out", fs_out, fs_in);
    rst_n = 1'b1;
    wr(3'd1, 16'd4); wr(3'd7, 16'h0003);
    for (int i = 0; i < 8; i++) begin
      item_t it;
      it.t = 1'b0; it.f = fs_in; it.tag = "R1";
      q.push_back(it);
    end
    drain();
    route_en = 1'b1;
    run_pattern(3, 2, 1, 4, 2, 1, 2'b00, 30, 1'b0, 1'b0, "R2_R3");
    run_pattern(1, 1, 2, 3, 0, 2, 2'b11, 20, 1'b0, 1'b0, "R4_R9");
    run_pattern(0, 0, 5, 0, 1, 1, 2'b10, 22, 1'b0, 1'b0, "R6_R9");
    route_en = 1'b0;
    run_pattern(3, 2, 1, 4, 2, 1, 2'b11, 25, 1'b0, 1'b1, "R7_R9");
    route_en = 1'b1;
    run_pattern(2, 2, 1, 1, 1, 0, 2'b00, 9, 1'b0, 1'b0, "R8");
    run_pattern(2, 3, 2, 2, 1, 0, 2'b11, 12, 1'b0, 1'b0, "R8_R4");
    run_pattern(4, 4, 4, 4, 0, 0, 2'b11, 10, 1'b0, 1'b0, "R5");
    run_pattern(2, 1, 1, 1, 1, 0, 2'b11, 12, 1'b1, 1'b0, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule